// File: doc/BRIEF.md
# Two-Way Set-Associative Tag Cache with Run-Time Victim Policy

This block models the tag side of a small two-way set-associative cache. It takes one block address per cycle and classifies it as a hit or a miss. On a miss it fills the indexed set. If that fill displaces a valid block, it reports the address of that block. The default geometry is two sets of two ways, four blocks in all. The block stores no data and handles no writes.

The victim way in a full set is chosen on every request from one of three policies, selected at run time: least recently used, most recently used, or a coin flip taken from an external random bit. An empty way is always filled before any valid way is displaced. Two running counters record hits and misses. Debug outputs expose every valid bit, every stored tag and every recency bit.

Typical use is to drive an address trace through the block and compare the hit/miss and eviction stream across the policies. The policy can change between requests without a flush.

Top module: `tagcache_top`

## Requirements
- R1: While rst_ni is low, all valid bits, recency bits and both counters are zero, and rsp_valid_o, hit_o, miss_o and evict_valid_o are low.
- R2: A request sampled with req_valid_i high at a rising edge gives its result in the cycle after that edge. In that cycle rsp_valid_o is high and exactly one of hit_o and miss_o is high. With no request, all four flags are low in the next cycle.
- R3: The set index is the low SET_W bits of the block address (bit 0 by default), and the tag is the remaining upper bits.
- R4: A request hits when its tag equals the stored tag of a valid way in its set. Otherwise it misses.
- R5: On a miss, an invalid way is filled before any valid way, with way 0 preferred, whatever the policy. Such a fill reports no eviction, and valid bits are never cleared except by reset.
- R6: With policy_i = 2'b00 or 2'b11, a miss in a full set replaces the way that was not the most recently used.
- R7: With policy_i = 2'b01, a miss in a full set replaces the most recently used way.
- R8: With policy_i = 2'b10, a miss in a full set replaces way 0 when rand_bit_i is 0 and way 1 when it is 1.
- R9: Each set's recency bit names the way touched by the latest hit or fill in that set. dbg_valid_o, dbg_tags_o and dbg_mru_o show the state, with way w of set s at index s*2+w.
- R10: evict_valid_o is high only on a miss that replaces a valid way. In that case evict_addr_o equals {old tag, set index}.
- R11: hit_count_o and miss_count_o together advance by exactly one for each accepted request and stay unchanged on idle cycles.
- R12: A change of policy_i takes effect on the very next request, with no loss of stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | ADDR_W | Block address |
| policy_i | input | 2 | 00/11 LRU, 01 MRU, 10 random |
| rand_bit_i | input | 1 | Coin used by the random policy |
| rsp_valid_o | output | 1 | Result valid |
| hit_o | output | 1 | Request hit |
| miss_o | output | 1 | Request missed |
| evict_valid_o | output | 1 | A valid block was displaced |
| evict_addr_o | output | ADDR_W | Address of the displaced block |
| hit_count_o | output | CNT_W | Hits since reset |
| miss_count_o | output | CNT_W | Misses since reset |
| dbg_valid_o | output | SETS*2 | Valid bit per way |
| dbg_tags_o | output | SETS*2*TAG_W | Stored tag per way |
| dbg_mru_o | output | SETS | Most recently used way per set |

## Verification
A wrong tag or valid bit can stay hidden on hit_o until the same set is referenced again. The debug ports expose it in the cycle after the write, so the bench compares them on every clock. A wrong recency bit is different. It shows on dbg_mru_o at once, but it reaches evict_addr_o only at the next miss in a full set of that set. For that reason the traces keep each set full while they switch between policies. A counter fault shows at once as a sum that moves by a step other than one per request.

// File: rtl/tagcache_pkg.sv
package tagcache_pkg;
  localparam int unsigned WAYS = 2;

  typedef enum logic [1:0] {
    POL_LRU  = 2'b00,
    POL_MRU  = 2'b01,
    POL_RAND = 2'b10,
    POL_LRU2 = 2'b11
  } policy_e;
endpackage

// File: rtl/tagcache_store.sv
module tagcache_store #(
  parameter int unsigned SETS  = 2,
  parameter int unsigned TAG_W = 7,
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              upd_i,
  input  logic [SET_W-1:0]                  upd_set_i,
  input  logic                              upd_way_i,
  input  logic                              upd_fill_i,
  input  logic [TAG_W-1:0]                  upd_tag_i,
  input  logic [SET_W-1:0]                  rd_set_i,
  output logic [tagcache_pkg::WAYS-1:0]     rd_valid_o,
  output logic [tagcache_pkg::WAYS-1:0][TAG_W-1:0] rd_tag_o,
  output logic                              rd_mru_o,
  output logic [SETS*tagcache_pkg::WAYS-1:0] dbg_valid_o,
  output logic [SETS*tagcache_pkg::WAYS*TAG_W-1:0] dbg_tags_o,
  output logic [SETS-1:0]                   dbg_mru_o
);
  localparam int unsigned WAYS = tagcache_pkg::WAYS;

  logic [SETS-1:0][WAYS-1:0]            set_valid;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] set_tag;
  logic [SETS-1:0]                      set_mru;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic [WAYS-1:0]            v_q;
    logic [WAYS-1:0][TAG_W-1:0] t_q;
    logic                       m_q;
    logic                       sel;

    assign sel = upd_i && (upd_set_i == SET_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= '0;
        t_q <= '0;
        m_q <= 1'b0;
      end else if (sel) begin
        m_q <= upd_way_i;
        if (upd_fill_i) begin
          v_q[upd_way_i] <= 1'b1;
          t_q[upd_way_i] <= upd_tag_i;
        end
      end
    end

    assign set_valid[g] = v_q;
    assign set_tag[g]   = t_q;
    assign set_mru[g]   = m_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign dbg_valid_o[g*WAYS+w] = v_q[w];
      assign dbg_tags_o[(g*WAYS+w)*TAG_W +: TAG_W] = t_q[w];
    end
  end

  assign rd_valid_o = set_valid[rd_set_i];
  assign rd_tag_o   = set_tag[rd_set_i];
  assign rd_mru_o   = set_mru[rd_set_i];
  assign dbg_mru_o  = set_mru;
endmodule

// File: rtl/tagcache_lookup.sv
module tagcache_lookup #(
  parameter int unsigned TAG_W = 7
) (
  input  logic [tagcache_pkg::WAYS-1:0]            valid_i,
  input  logic [tagcache_pkg::WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]                         req_tag_i,
  output logic                                     hit_o,
  output logic                                     hit_way_o
);
  logic [tagcache_pkg::WAYS-1:0] match;

  for (genvar w = 0; w < tagcache_pkg::WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tag_i[w] == req_tag_i);
  end

  assign hit_o     = |match;
  assign hit_way_o = match[1];
endmodule

// File: rtl/tagcache_victim.sv
module tagcache_victim
  import tagcache_pkg::*;
(
  input  logic [WAYS-1:0] valid_i,
  input  logic            mru_i,
  input  logic [1:0]      policy_i,
  input  logic            rand_bit_i,
  output logic            way_o
);
  policy_e pol;
  assign pol = policy_e'(policy_i);

  always_comb begin
    if (!valid_i[0])      way_o = 1'b0;
    else if (!valid_i[1]) way_o = 1'b1;
    else begin
      unique case (pol)
        POL_MRU:  way_o = mru_i;
        POL_RAND: way_o = rand_bit_i;
        default:  way_o = ~mru_i;
      endcase
    end
  end
endmodule

// File: rtl/tagcache_top.sv
module tagcache_top #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SETS   = 2,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned TAG_W = ADDR_W - SET_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [1:0]               policy_i,
  input  logic                     rand_bit_i,
  output logic                     rsp_valid_o,
  output logic                     hit_o,
  output logic                     miss_o,
  output logic                     evict_valid_o,
  output logic [ADDR_W-1:0]        evict_addr_o,
  output logic [CNT_W-1:0]         hit_count_o,
  output logic [CNT_W-1:0]         miss_count_o,
  output logic [SETS*2-1:0]        dbg_valid_o,
  output logic [SETS*2*TAG_W-1:0]  dbg_tags_o,
  output logic [SETS-1:0]          dbg_mru_o
);
  localparam int unsigned WAYS = tagcache_pkg::WAYS;

  logic [SET_W-1:0]            req_set;
  logic [TAG_W-1:0]            req_tag;
  logic [WAYS-1:0]             rd_valid;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic                        rd_mru;
  logic                        lk_hit, lk_way, vic_way, upd_way;

  assign req_set = req_addr_i[SET_W-1:0];
  assign req_tag = req_addr_i[ADDR_W-1:SET_W];
  assign upd_way = lk_hit ? lk_way : vic_way;

  tagcache_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (req_valid_i),
    .upd_set_i  (req_set),
    .upd_way_i  (upd_way),
    .upd_fill_i (!lk_hit),
    .upd_tag_i  (req_tag),
    .rd_set_i   (req_set),
    .rd_valid_o (rd_valid),
    .rd_tag_o   (rd_tag),
    .rd_mru_o   (rd_mru),
    .dbg_valid_o(dbg_valid_o),
    .dbg_tags_o (dbg_tags_o),
    .dbg_mru_o  (dbg_mru_o)
  );

  tagcache_lookup #(.TAG_W(TAG_W)) u_lookup (
    .valid_i  (rd_valid),
    .tag_i    (rd_tag),
    .req_tag_i(req_tag),
    .hit_o    (lk_hit),
    .hit_way_o(lk_way)
  );

  tagcache_victim u_victim (
    .valid_i   (rd_valid),
    .mru_i     (rd_mru),
    .policy_i  (policy_i),
    .rand_bit_i(rand_bit_i),
    .way_o     (vic_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      hit_o         <= 1'b0;
      miss_o        <= 1'b0;
      evict_valid_o <= 1'b0;
      evict_addr_o  <= '0;
      hit_count_o   <= '0;
      miss_count_o  <= '0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      hit_o         <= req_valid_i && lk_hit;
      miss_o        <= req_valid_i && !lk_hit;
      evict_valid_o <= req_valid_i && !lk_hit && rd_valid[vic_way];
      evict_addr_o  <= (req_valid_i && !lk_hit && rd_valid[vic_way]) ?
                       {rd_tag[vic_way], req_set} : '0;
      if (req_valid_i) begin
        if (lk_hit) hit_count_o  <= hit_count_o + 1'b1;
        else        miss_count_o <= miss_count_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tagcache_checker.sv
module tagcache_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SETS   = 2,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic              hit_o,
  input logic              miss_o,
  input logic              evict_valid_o,
  input logic [ADDR_W-1:0] evict_addr_o,
  input logic [CNT_W-1:0]  hit_count_o,
  input logic [CNT_W-1:0]  miss_count_o,
  input logic [SETS*2-1:0] dbg_valid_o
);
  logic [CNT_W-1:0] cnt_sum;
  assign cnt_sum = hit_count_o + miss_count_o;

  a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r2_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !hit_o && !miss_o && !evict_valid_o);

  a_r2_hit_xor_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (hit_o ^ miss_o));

  a_r10_evict_needs_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> miss_o);

  a_r10_evict_same_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> !evict_valid_o ||
      (evict_addr_o[SET_W-1:0] == $past(req_addr_i[SET_W-1:0]) &&
       evict_addr_o != $past(req_addr_i)));

  a_r11_one_count_per_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> cnt_sum == CNT_W'($past(cnt_sum) + 1'b1));

  a_r11_counts_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(hit_count_o) && $stable(miss_count_o));

  a_r5_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_valid_o & $past(dbg_valid_o)) == $past(dbg_valid_o));
endmodule

bind tagcache_top tagcache_checker #(.ADDR_W(ADDR_W), .SETS(SETS), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .rsp_valid_o  (rsp_valid_o),
  .hit_o        (hit_o),
  .miss_o       (miss_o),
  .evict_valid_o(evict_valid_o),
  .evict_addr_o (evict_addr_o),
  .hit_count_o  (hit_count_o),
  .miss_count_o (miss_count_o),
  .dbg_valid_o  (dbg_valid_o)
);

// File: tb/tagcache_top_test.sv
module tagcache_top_test;
  localparam int ADDR_W = 8;
  localparam int SETS   = 2;
  localparam int CNT_W  = 16;
  localparam int TAG_W  = ADDR_W - 1;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0] policy_i = 2'b00;
  logic rand_bit_i = 1'b0;
  logic rsp_valid_o, hit_o, miss_o, evict_valid_o;
  logic [ADDR_W-1:0] evict_addr_o;
  logic [CNT_W-1:0] hit_count_o, miss_count_o;
  logic [SETS*2-1:0] dbg_valid_o;
  logic [SETS*2*TAG_W-1:0] dbg_tags_o;
  logic [SETS-1:0] dbg_mru_o;

  always #5 clk = ~clk;

  tagcache_top #(.ADDR_W(ADDR_W), .SETS(SETS), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .policy_i(policy_i), .rand_bit_i(rand_bit_i), .rsp_valid_o(rsp_valid_o),
    .hit_o(hit_o), .miss_o(miss_o), .evict_valid_o(evict_valid_o),
    .evict_addr_o(evict_addr_o), .hit_count_o(hit_count_o), .miss_count_o(miss_count_o),
    .dbg_valid_o(dbg_valid_o), .dbg_tags_o(dbg_tags_o), .dbg_mru_o(dbg_mru_o)
  );

  int n_checks = 0, n_errors = 0, cyc = 0;
  bit done = 0;

  // reference model
  int  m_tag [SETS][2];
  bit  m_v   [SETS][2];
  int  m_mru [SETS];
  int  n_hit = 0, n_miss = 0;
  bit  e_rv = 0, e_hit = 0, e_ev = 0;
  int  e_ea = 0;
  string last_req = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      m_mru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_v[s][w] = 0; m_tag[s][w] = 0; end
    end
    n_hit = 0; n_miss = 0; e_rv = 0; e_hit = 0; e_ev = 0; e_ea = 0;
  endtask

  task automatic compare(input string req);
    check(rsp_valid_o == e_rv, req, "rsp_valid", int'(rsp_valid_o), int'(e_rv));
    if (e_rv) begin
      check(hit_o == e_hit && miss_o == !e_hit, req, "hit", int'(hit_o), int'(e_hit));
      check(evict_valid_o == e_ev, req, "evict_valid", int'(evict_valid_o), int'(e_ev));
      if (e_ev) check(int'(evict_addr_o) == e_ea, req, "evict_addr", int'(evict_addr_o), e_ea);
    end else begin
      check(!hit_o && !miss_o && !evict_valid_o, "R2", "idle flags",
            int'({hit_o, miss_o, evict_valid_o}), 0);
    end
    check(int'(hit_count_o) == n_hit, "R11", "hit_count", int'(hit_count_o), n_hit);
    check(int'(miss_count_o) == n_miss, "R11", "miss_count", int'(miss_count_o), n_miss);
    for (int s = 0; s < SETS; s++) begin
      check(int'(dbg_mru_o[s]) == m_mru[s], "R9", "mru", int'(dbg_mru_o[s]), m_mru[s]);
      for (int w = 0; w < 2; w++) begin
        check(dbg_valid_o[s*2+w] == m_v[s][w], "R9", "valid",
              int'(dbg_valid_o[s*2+w]), int'(m_v[s][w]));
        if (m_v[s][w])
          check(int'(dbg_tags_o[(s*2+w)*TAG_W +: TAG_W]) == m_tag[s][w], "R3", "tag",
                int'(dbg_tags_o[(s*2+w)*TAG_W +: TAG_W]), m_tag[s][w]);
      end
    end
  endtask

  task automatic step(input bit v, input int a, input int pol, input bit rb, input string req);
    int s, t, hw, vic;
    @(negedge clk);
    compare(last_req);
    last_req = req;
    e_rv = v; e_hit = 0; e_ev = 0; e_ea = 0;
    if (v) begin
      s = a % SETS; t = a / SETS; hw = -1;
      for (int w = 0; w < 2; w++) if (m_v[s][w] && m_tag[s][w] == t) hw = w;
      if (hw >= 0) begin
        e_hit = 1; m_mru[s] = hw; n_hit++;
      end else begin
        if (!m_v[s][0]) vic = 0;
        else if (!m_v[s][1]) vic = 1;
        else if (pol == 1) vic = m_mru[s];
        else if (pol == 2) vic = int'(rb);
        else vic = 1 - m_mru[s];
        e_ev = m_v[s][vic];
        e_ea = m_tag[s][vic] * SETS + s;
        m_v[s][vic] = 1; m_tag[s][vic] = t; m_mru[s] = vic; n_miss++;
      end
    end
    req_valid_i = v;
    req_addr_i  = ADDR_W'(a);
    policy_i    = 2'(pol);
    rand_bit_i  = rb;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; req_valid_i = 1'b0;
    model_clear();
    #1;
    compare("R1");
    @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    last_req = "R1";
  endtask

  task automatic trace(input int pol, input string req);
    int seq [9] = '{1, 3, 5, 1, 3, 1, 3, 5, 3};
    foreach (seq[i]) step(1'b1, seq[i], pol, 1'b0, req);
    step(1'b0, 0, pol, 1'b0, "R2");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_CYCLES && !done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WD_CYCLES);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (2) @(negedge clk);
    do_reset();
    // R5: way 0 first, then way 1, no evictions
    step(1'b1, 4, 1, 1'b1, "R5");
    step(1'b1, 6, 1, 1'b0, "R5");
    step(1'b1, 4, 1, 1'b0, "R4");
    step(1'b1, 255, 0, 1'b0, "R3");
    step(1'b0, 0, 0, 1'b0, "R11");
    step(1'b0, 0, 0, 1'b0, "R11");
    step(1'b1, 201, 0, 1'b0, "R3");
    trace(0, "R6");
    do_reset();
    trace(1, "R7");
    do_reset();
    // R8: coin flips
    step(1'b1, 2, 2, 1'b1, "R8");
    step(1'b1, 8, 2, 1'b1, "R8");
    step(1'b1, 10, 2, 1'b0, "R8");
    step(1'b1, 12, 2, 1'b1, "R8");
    step(1'b1, 14, 2, 1'b1, "R8");
    step(1'b1, 16, 2, 1'b0, "R8");
    trace(2, "R8");
    // R6: policy 11 behaves as LRU
    trace(3, "R6");
    // R12: policy switches back to back on full sets
    step(1'b1, 20, 0, 1'b0, "R12");
    step(1'b1, 22, 0, 1'b0, "R12");
    step(1'b1, 20, 1, 1'b0, "R12");
    step(1'b1, 24, 1, 1'b0, "R12");
    step(1'b1, 26, 0, 1'b0, "R12");
    step(1'b1, 28, 2, 1'b1, "R12");
    step(1'b1, 24, 2, 1'b0, "R10");
    step(1'b1, 129, 0, 1'b0, "R10");
    step(1'b1, 131, 1, 1'b1, "R10");
    for (int i = 0; i < 40; i++)
      step(1'b1, (i * 7 + 3) % 32, i % 4, 1'(i / 3), "R10");
    step(1'b0, 0, 0, 1'b0, "R2");
    step(1'b0, 0, 0, 1'b0, "R2");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule